// File: doc/BRIEF.md
# Prescaled Memory Timing Divider

This block produces the slow timing enable that paces the program and erase sequencers of a non-volatile memory controller. It runs on the fast oscillator clock. It emits a single-cycle enable pulse at a programmable sub-multiple of that clock. It does not produce a derived clock, so all downstream logic stays in the oscillator domain.

Software writes one configuration register. The register holds a prescale-enable bit and a 6-bit divide field. When prescaling is on, the oscillator is first divided by a fixed factor (8 by default), and the programmable stage then divides by the field value plus one. The total ratio is chosen to place the pacing rate between 150 kHz and 200 kHz. The prescaler must be enabled whenever the oscillator runs above 12.8 MHz.

A sticky "configured" flag is set by the first write after reset. The command logic checks this flag and rejects any program or erase attempt made while it is low, reporting that attempt as an access error. Every write restarts both counting stages from zero, so a reconfiguration never yields a shortened period.

Top module: `mem_clk_div`

## Requirements
- R1: After reset `rd_data_o` reads 0, `loaded_o` is 0 and `tick_o` is 0. All three stay at those values until the first write.
- R2: Any write sets `loaded_o`, and it stays set until reset. `rd_data_o[7]` mirrors `loaded_o` from the cycle after the write onward. Later writes cannot clear it.
- R3: A write stores `wr_data_i[6]` as the prescale-enable bit and `wr_data_i[5:0]` as the divide field N. From the next cycle, these read back on `rd_data_o[6]` and `rd_data_o[5:0]`.
- R4: With prescale-enable 0, `tick_o` pulses with a period of N+1 oscillator cycles. The first pulse is in the cycle N clock edges after the write edge. With N=0, `tick_o` is high every cycle.
- R5: With prescale-enable 1, `tick_o` pulses with a period of 8*(N+1) cycles. The first pulse is in the cycle 8*(N+1)-1 edges after the write edge.
- R6: A write restarts both counting stages. The first pulse after a write follows the R4/R5 timing of the new setting, wherever the old count stood.
- R7: Unless prescaling is off and N=0, every pulse of `tick_o` lasts exactly one cycle, provided no write intervenes.
- R8: `tick_o` is never high while `loaded_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Configuration write strobe |
| wr_data_i | input | 7 | Write data: [6] prescale enable, [5:0] divide field |
| rd_data_o | output | 8 | Read data: [7] loaded, [6] prescale enable, [5:0] divide field |
| tick_o | output | 1 | Single-cycle pacing enable |
| loaded_o | output | 1 | Configured-since-reset flag for command error checking |

## Verification
The register readback and the loaded flag are due in the cycle that follows the write edge. The bench samples them at the next falling edge. The first pacing pulse is due P-1 edges after the write edge, where P is (N+1) without prescaling and 8*(N+1) with it. The bench numbers falling edges from the write and expects a pulse exactly where the index plus one is a multiple of P. It sweeps all 64 divide values in both prescale modes, observes two full periods of each, and repeats a restart mid-period to confirm that the phase realigns to the write.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int unsigned DIV_W = 6;

  typedef struct packed {
    logic             pre_en;
    logic [DIV_W-1:0] div;
  } mcd_cfg_t;

  localparam int unsigned CFG_W = $bits(mcd_cfg_t);
endpackage

// File: rtl/mcd_cfg_reg.sv
module mcd_cfg_reg
  import mcd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [CFG_W-1:0]     wr_data_i,
  output mcd_cfg_t             cfg_o,
  output logic                 loaded_o
);
  mcd_cfg_t cfg_q;
  logic     loaded_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q    <= '0;
      loaded_q <= 1'b0;
    end else if (wr_en_i) begin
      cfg_q    <= mcd_cfg_t'(wr_data_i);
      loaded_q <= 1'b1;  // sticky until reset
    end
  end

  assign cfg_o    = cfg_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/mcd_prescaler.sv
module mcd_prescaler #(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic run_i,
  input  logic pre_en_i,
  output logic step_o
);
  generate
    if (PRE_DIV > 1) begin : g_cnt
      localparam int unsigned PW = $clog2(PRE_DIV);
      localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
      logic [PW-1:0] pcnt_q;
      logic          wrap;

      assign wrap = (pcnt_q == LAST);

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  pcnt_q <= '0;
        else if (restart_i)           pcnt_q <= '0;
        else if (run_i && pre_en_i)   pcnt_q <= wrap ? '0 : pcnt_q + 1'b1;
      end

      assign step_o = run_i & (~pre_en_i | wrap);
    end else begin : g_pass
      assign step_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/mcd_divider.sv
module mcd_divider #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         restart_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;
  logic         wrap;

  assign wrap = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (step_i)    cnt_q <= wrap ? '0 : cnt_q + 1'b1;
  end

  assign tick_o = step_i & wrap;
endmodule

// File: rtl/mem_clk_div.sv
module mem_clk_div
  import mcd_pkg::*;
#(
  parameter int unsigned PRE_DIV = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [CFG_W-1:0]   wr_data_i,
  output logic [CFG_W:0]     rd_data_o,
  output logic               tick_o,
  output logic               loaded_o
);
  mcd_cfg_t cfg;
  logic     loaded;
  logic     step;

  mcd_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .cfg_o    (cfg),
    .loaded_o (loaded)
  );

  mcd_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(wr_en_i),
    .run_i    (loaded),
    .pre_en_i (cfg.pre_en),
    .step_o   (step)
  );

  mcd_divider #(.W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(wr_en_i),
    .step_i   (step),
    .limit_i  (cfg.div),
    .tick_o   (tick_o)
  );

  assign rd_data_o = {loaded, cfg};
  assign loaded_o  = loaded;
endmodule

// File: rtl/mcd_checker.sv
module mcd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [6:0] wr_data_i,
  input logic [7:0] rd_data_o,
  input logic       tick_o,
  input logic       loaded_o
);
  a_r8_no_tick_unloaded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loaded_o |-> !tick_o);

  a_r2_loaded_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |=> loaded_o);

  a_r2_write_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (loaded_o && rd_data_o[7]));

  a_r3_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[6:0] == $past(wr_data_i));

  a_r6_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_data_i[6] || wr_data_i[5:0] != 6'd0)) |=> !tick_o);

  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && tick_o && (rd_data_o[6] || rd_data_o[5:0] != 6'd0)) |=> !tick_o);
endmodule

bind mem_clk_div mcd_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_data_i(wr_data_i),
  .rd_data_o(rd_data_o),
  .tick_o   (tick_o),
  .loaded_o (loaded_o)
);

// File: tb/mem_clk_div_bench.sv
`timescale 1ns/1ps
module mem_clk_div_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [6:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tick, loaded;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  mem_clk_div u_mem_clk_div (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .tick_o(tick), .loaded_o(loaded)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Write on a falling edge; returns at the falling edge after the capture edge (cycle 0).
  task automatic wr_cfg(input bit pre, input int n);
    @(negedge clk);
    wr_en = 1'b1; wr_data = {pre, 6'(n)};
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // Observe cycles 0..len-1 after a write; count mismatches against period p.
  task automatic watch(input int p, input int len, output int miss);
    miss = 0;
    for (int i = 0; i < len; i++) begin
      if (tick != (((i + 1) % p) == 0)) miss++;
      @(negedge clk);
    end
  endtask

  initial begin
    int miss, lo, hi;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R8: idle after reset
    lo = 0; hi = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rd_data != 8'd0 || loaded) lo++;
      if (tick) hi++;
    end
    check("R1 reset readback/loaded", lo, 0);
    check("R8 no tick before load", hi, 0);

    // R2/R3/R4: prescale off sweep
    for (int n = 0; n < 64; n++) begin
      wr_cfg(1'b0, n);
      check("R3 readback off", int'(rd_data), 128 + n);
      check("R2 loaded", int'(loaded), 1);
      watch(n + 1, 2 * (n + 1) + 2, miss);
      check("R4 period N+1", miss, 0);
    end

    // R5: prescale on sweep
    for (int n = 0; n < 64; n++) begin
      wr_cfg(1'b1, n);
      check("R3 readback on", int'(rd_data), 192 + n);
      watch(8 * (n + 1), 16 * (n + 1) + 2, miss);
      check("R5 period 8*(N+1)", miss, 0);
    end

    // R6: restart mid-period, both modes
    wr_cfg(1'b0, 10);
    repeat (4) @(negedge clk);
    wr_cfg(1'b0, 10);
    watch(11, 30, miss);
    check("R6 restart no prescale", miss, 0);
    wr_cfg(1'b1, 3);
    repeat (13) @(negedge clk);
    wr_cfg(1'b1, 3);
    watch(32, 70, miss);
    check("R6 restart prescale", miss, 0);

    // R7: pulse width one cycle
    wr_cfg(1'b0, 1);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      if (tick) begin
        @(negedge clk);
        if (tick) hi++;
      end else @(negedge clk);
    end
    check("R7 single-cycle pulse", hi, 0);

    // R2: still set after more writes, bit 7 not writable
    wr_cfg(1'b0, 0);
    check("R2 sticky loaded bit", int'(rd_data[7]), 1);
    watch(1, 10, miss);
    check("R4 N=0 continuous", miss, 0);

    // R1/R8: reset clears again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset clears", int'({loaded, tick, rd_data}), 0);
    rst_n = 1'b1;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule